// File: doc/BRIEF.md
# ZA Quad-Vector Group Row Sequencer

This block generates the walk through the ZA array that a multi-vector widening multiply-add needs. A one-cycle start pulse launches a sequence. At that pulse the block captures a 32-bit base value taken from the chosen vector-select register, an encoded offset field, a register-count code and an encoded first-source field. It also captures the number of ZA vectors, which is the vector length in bytes.

From these values it works out a quad-aligned starting row and a stride. It then steps once per clock through every ZA row of every quad-vector group. With each step it presents the row number, the source vector register that feeds that row and the sub-vector index inside the quad.

A datapath beside it consumes the step stream: it reads the sources, multiplies and accumulates. The sequencer does no arithmetic on element data and holds no array storage. The selected vector-select register is one of four, numbered 8 plus a 2-bit field. Register-file read of that value happens outside this block.

Top module: `zaq_row_seq`

## Requirements
- R1: While reset is held, and after it is released with no start, `vld_o` and `done_o` are both low.
- R2: The row offset equals the offset field times 4. With a count code of 0 (one group) both bits of `off_fld_i` are used. With codes 1 and 2 only bit 0 is used and bit 1 has no effect.
- R3: The stride is `za_vecs_i` divided by the group count. The count code 0 means 1 group, 1 means 2 groups and 2 means 4 groups. The first row is the remainder of base plus offset divided by the stride, rounded down to a multiple of 4. `za_vecs_i` must be a power of two from 16 to 256.
- R4: An accepted start yields 4 × groups valid steps on consecutive cycles, beginning the cycle after the start edge. The group r is the outer loop and the index i from 0 to 3 is the inner loop. Each step shows row = first row + r × stride + i and `sub_o` = i.
- R5: During group r, `src_o` = n + r. n is `src_fld_i[4:0]` for code 0, `src_fld_i[3:0]` × 2 for code 1, and `src_fld_i[2:0]` × 4 for code 2.
- R6: `done_o` is high for exactly one cycle, the cycle right after the last valid step. `vld_o` is low in that cycle.
- R7: A start that arrives while valid steps are still being issued is ignored. The running sequence continues unchanged and no extra steps follow.
- R8: A start with count code 3 is ignored: no valid step and no done pulse follow it.
- R9: A start that arrives in the cycle in which `done_o` is high is accepted. Its first step appears in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Launch pulse; operands sampled at this edge |
| vsel_base_i | input | 32 | Value of the selected vector-select register |
| off_fld_i | input | 2 | Encoded row offset field (offset = field × 4) |
| nreg_i | input | 2 | Group count code: 0 → 1, 1 → 2, 2 → 4, 3 reserved |
| src_fld_i | input | 5 | Encoded first-source register field |
| za_vecs_i | input | 9 | Number of ZA vectors (vector length in bytes) |
| vld_o | output | 1 | Step valid |
| row_o | output | 8 | ZA row for this step |
| src_o | output | 5 | Source vector register for this step |
| sub_o | output | 2 | Sub-vector index i inside the quad |
| done_o | output | 1 | One-cycle pulse after the final step |

## Verification
The first step of an accepted launch is due one cycle after the start edge, because the operands pass through one register stage. The following steps come one cycle apart, and the done pulse arrives one cycle after the last step. The bench model turns each launch it accepts into a queue of expected per-cycle outputs, with one entry for each step and then one done entry. Each falling edge pops exactly one entry, or expects idle outputs when the queue is empty, so every result is compared in the cycle where it falls due. The model decides whether a start is accepted from its own queue occupancy. This covers starts that arrive while busy, starts in the done cycle and starts with the reserved count code.

// File: rtl/zaq_pkg.sv
package zaq_pkg;

   // group count code carried on nreg_i
   typedef enum logic [1:0] {
      NREG_X1   = 2'd0,
      NREG_X2   = 2'd1,
      NREG_X4   = 2'd2,
      NREG_RSVD = 2'd3
   } nreg_e;

   localparam int unsigned QUAD_ROWS = 4;
   localparam int unsigned MAX_GROUPS = 4;

   // index of the last group for a given count code
   function automatic logic [1:0] last_group(nreg_e code);
      case (code)
         NREG_X1: last_group = 2'd0;
         NREG_X2: last_group = 2'd1;
         default: last_group = 2'd3;
      endcase
   endfunction

   // log2 of the group count
   function automatic logic [1:0] group_shift(nreg_e code);
      case (code)
         NREG_X1: group_shift = 2'd0;
         NREG_X2: group_shift = 2'd1;
         default: group_shift = 2'd2;
      endcase
   endfunction

endpackage

// File: rtl/zaq_addr_calc.sv
module zaq_addr_calc
   import zaq_pkg::*;
#(
   parameter int unsigned BASE_W      = 32,
   parameter int unsigned ROW_W       = 8,
   parameter int unsigned REG_W       = 5,
   parameter int unsigned OFF_W       = 2,
   parameter bit          MOD_BY_MASK = 1'b1
) (
   input  logic [BASE_W-1:0] base_i,
   input  logic [OFF_W-1:0]  off_fld_i,
   input  nreg_e             nreg_i,
   input  logic [REG_W-1:0]  src_fld_i,
   input  logic [ROW_W:0]    vecs_i,
   output logic [ROW_W-1:0]  start_row_o,
   output logic [ROW_W:0]    stride_o,
   output logic [REG_W-1:0]  src_base_o
);

   localparam int unsigned VEC_W    = ROW_W + 1;
   localparam int unsigned N_SRC_V  = 3;

   logic [OFF_W-1:0]  off_eff;
   logic [BASE_W-1:0] sum_full;
   logic [VEC_W-1:0]  mask;
   logic [ROW_W-1:0]  mod_row;
   logic [REG_W-1:0]  src_cand [N_SRC_V];

   // the multi-group forms carry a single offset bit
   always_comb begin
      if (nreg_i == NREG_X1) off_eff = off_fld_i;
      else                   off_eff = {{(OFF_W-1){1'b0}}, off_fld_i[0]};
   end

   assign sum_full = base_i + (BASE_W'(off_eff) << 2);
   assign stride_o = vecs_i >> group_shift(nreg_i);
   assign mask     = stride_o - VEC_W'(1);

   generate
      if (MOD_BY_MASK) begin : g_mod_mask
         // stride is a power of two: modulo is a bit mask
         assign mod_row = ROW_W'(sum_full & BASE_W'(mask));
      end else begin : g_mod_div
         assign mod_row = (stride_o == '0) ? '0
                        : ROW_W'(sum_full % BASE_W'(stride_o));
      end
   endgenerate

   // force the start down to a quad boundary
   assign start_row_o = mod_row & ~ROW_W'(QUAD_ROWS - 1);

   // first source register: field scaled by the group count
   generate
      for (genvar k = 0; k < N_SRC_V; k++) begin : g_src
         assign src_cand[k] =
            (src_fld_i & REG_W'((1 << (REG_W - k)) - 1)) << k;
      end
   endgenerate

   assign src_base_o = src_cand[group_shift(nreg_i)];

endmodule

// File: rtl/zaq_step_ctr.sv
module zaq_step_ctr
   import zaq_pkg::*;
#(
   parameter int unsigned SUB_W = 2,
   parameter int unsigned GRP_W = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             req_i,
   input  logic             ok_i,
   input  logic [GRP_W-1:0] last_grp_i,
   output logic             take_o,
   output logic             busy_o,
   output logic             adv_o,
   output logic [GRP_W-1:0] grp_o,
   output logic [SUB_W-1:0] sub_o,
   output logic             done_o
);

   logic             busy_q;
   logic             done_q;
   logic [GRP_W-1:0] grp_q;
   logic [GRP_W-1:0] last_q;
   logic [SUB_W-1:0] sub_q;
   logic             quad_end;
   logic             final_step;

   assign take_o     = req_i && ok_i && !busy_q;
   assign quad_end   = busy_q && (sub_q == '1);
   assign final_step = quad_end && (grp_q == last_q);
   assign adv_o      = quad_end && !final_step;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         busy_q <= 1'b0;
         done_q <= 1'b0;
         grp_q  <= '0;
         sub_q  <= '0;
         last_q <= '0;
      end else begin
         done_q <= final_step;
         if (take_o) begin
            busy_q <= 1'b1;
            grp_q  <= '0;
            sub_q  <= '0;
            last_q <= last_grp_i;
         end else if (busy_q) begin
            sub_q <= sub_q + 1'b1;
            if (quad_end) grp_q <= grp_q + 1'b1;
            if (final_step) busy_q <= 1'b0;
         end
      end
   end

   assign busy_o = busy_q;
   assign grp_o  = grp_q;
   assign sub_o  = sub_q;
   assign done_o = done_q;

   AST_BUSY_RUNS_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_q && !final_step |=> busy_q && (sub_q == $past(sub_q) + 1'b1)); // R7
   AST_RSVD_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !busy_q && req_i && !ok_i |=> !busy_q && !done_q); // R8
   AST_DONE_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
      final_step |=> done_q && $past(busy_q)); // R6

endmodule

// File: rtl/zaq_row_track.sv
module zaq_row_track #(
   parameter int unsigned ROW_W = 8,
   parameter int unsigned REG_W = 5
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             take_i,
   input  logic             adv_i,
   input  logic [ROW_W-1:0] start_row_i,
   input  logic [ROW_W:0]   stride_i,
   input  logic [REG_W-1:0] src_base_i,
   output logic [ROW_W-1:0] row_base_o,
   output logic [REG_W-1:0] src_o
);

   logic [ROW_W-1:0] row_base_q;
   logic [ROW_W:0]   stride_q;
   logic [REG_W-1:0] src_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         row_base_q <= '0;
         stride_q   <= '0;
         src_q      <= '0;
      end else if (take_i) begin
         row_base_q <= start_row_i;
         stride_q   <= stride_i;
         src_q      <= src_base_i;
      end else if (adv_i) begin
         row_base_q <= ROW_W'({1'b0, row_base_q} + stride_q);
         src_q      <= src_q + 1'b1;
      end
   end

   assign row_base_o = row_base_q;
   assign src_o      = src_q;

   AST_GROUP_STRIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      adv_i && !take_i |=> row_base_q == ROW_W'({1'b0, $past(row_base_q)} + stride_q)); // R4
   AST_SRC_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      adv_i && !take_i |=> src_q == $past(src_q) + 1'b1); // R5

endmodule

// File: rtl/zaq_row_seq.sv
module zaq_row_seq
   import zaq_pkg::*;
#(
   parameter int unsigned BASE_W      = 32,
   parameter int unsigned MAX_VECS    = 256,
   parameter int unsigned MIN_VECS    = 16,
   parameter int unsigned REG_W       = 5,
   parameter int unsigned OFF_W       = 2,
   parameter bit          MOD_BY_MASK = 1'b1,
   localparam int unsigned ROW_W      = $clog2(MAX_VECS),
   localparam int unsigned VEC_W      = ROW_W + 1,
   localparam int unsigned SUB_W      = $clog2(QUAD_ROWS),
   localparam int unsigned GRP_W      = $clog2(MAX_GROUPS)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              start_i,
   input  logic [BASE_W-1:0] vsel_base_i,
   input  logic [OFF_W-1:0]  off_fld_i,
   input  logic [1:0]        nreg_i,
   input  logic [REG_W-1:0]  src_fld_i,
   input  logic [VEC_W-1:0]  za_vecs_i,
   output logic              vld_o,
   output logic [ROW_W-1:0]  row_o,
   output logic [REG_W-1:0]  src_o,
   output logic [SUB_W-1:0]  sub_o,
   output logic              done_o
);

   // elaboration-time parameter checks
   generate
      if ((MAX_VECS & (MAX_VECS - 1)) != 0) begin : g_bad_max
         $error("MAX_VECS must be a power of two");
      end
      if (MIN_VECS < MAX_GROUPS * QUAD_ROWS || MIN_VECS > MAX_VECS) begin : g_bad_min
         $error("MIN_VECS must hold four quads and not exceed MAX_VECS");
      end
      if (BASE_W < ROW_W) begin : g_bad_base
         $error("BASE_W narrower than the row address");
      end
      if (REG_W < 3 || OFF_W < 1) begin : g_bad_fld
         $error("field widths too small");
      end
   endgenerate

   nreg_e            code;
   logic [ROW_W-1:0] start_row;
   logic [VEC_W-1:0] stride;
   logic [REG_W-1:0] src_base;
   logic             take;
   logic             busy;
   logic             adv;
   logic [GRP_W-1:0] grp;
   logic [SUB_W-1:0] sub;
   logic [ROW_W-1:0] row_base;

   assign code = nreg_e'(nreg_i);

   zaq_addr_calc #(
      .BASE_W     (BASE_W),
      .ROW_W      (ROW_W),
      .REG_W      (REG_W),
      .OFF_W      (OFF_W),
      .MOD_BY_MASK(MOD_BY_MASK)
   ) u_addr (
      .base_i     (vsel_base_i),
      .off_fld_i  (off_fld_i),
      .nreg_i     (code),
      .src_fld_i  (src_fld_i),
      .vecs_i     (za_vecs_i),
      .start_row_o(start_row),
      .stride_o   (stride),
      .src_base_o (src_base)
   );

   zaq_step_ctr #(
      .SUB_W(SUB_W),
      .GRP_W(GRP_W)
   ) u_ctr (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .req_i     (start_i),
      .ok_i      (code != NREG_RSVD),
      .last_grp_i(GRP_W'(last_group(code))),
      .take_o    (take),
      .busy_o    (busy),
      .adv_o     (adv),
      .grp_o     (grp),
      .sub_o     (sub),
      .done_o    (done_o)
   );

   zaq_row_track #(
      .ROW_W(ROW_W),
      .REG_W(REG_W)
   ) u_track (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .take_i     (take),
      .adv_i      (adv),
      .start_row_i(start_row),
      .stride_i   (stride),
      .src_base_i (src_base),
      .row_base_o (row_base),
      .src_o      (src_o)
   );

   assign vld_o = busy;
   assign sub_o = sub;
   assign row_o = row_base + ROW_W'(sub);

   AST_VLD_DONE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> !vld_o); // R6
   AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !done_o); // R6
   AST_ROW_INCR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      vld_o && (sub_o != '0) |-> row_o == $past(row_o) + 1'b1); // R4
   AST_FIRST_ROW_QUAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      vld_o && !$past(vld_o) |-> (row_o[1:0] == 2'b00) && (sub_o == '0)); // R3
   AST_GROUP_ZERO_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
      vld_o && !$past(vld_o) |-> grp == '0); // R4
   AST_VECS_POW2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_i && !vld_o |-> $onehot(za_vecs_i)); // R3

endmodule

// File: tb/sim_zaq_row_seq.sv
module sim_zaq_row_seq;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 20000;

   typedef struct {
      bit vld;
      bit done;
      int row;
      int src;
      int sub;
   } ent_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] base = '0;
   logic [1:0]  off = '0;
   logic [1:0]  nreg = '0;
   logic [4:0]  srcf = '0;
   logic [8:0]  vecs = 9'd16;
   logic        vld, done;
   logic [7:0]  row;
   logic [4:0]  src;
   logic [1:0]  sub;

   int   checks = 0;
   int   errors = 0;
   bit   finished = 0;
   string scn = "R1";
   ent_t q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   zaq_row_seq u0 (
      .clk_i(clk), .rst_ni(rst_n), .start_i(start), .vsel_base_i(base),
      .off_fld_i(off), .nreg_i(nreg), .src_fld_i(srcf), .za_vecs_i(vecs),
      .vld_o(vld), .row_o(row), .src_o(src), .sub_o(sub), .done_o(done)
   );

   task automatic chk(bit ok, string tag, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s [%s] act=%0d exp=%0d t=%0t", tag, scn, act, exp, $time);
      end
   endtask

   // reference: expected output stream for one accepted launch
   task automatic push_launch(logic [31:0] b, logic [1:0] of, logic [1:0] nc,
                              logic [4:0] sf, int vc);
      int     groups = 1 << nc;
      int     offv   = (nc == 0) ? int'(of) : int'(of & 2'b01);
      int     stride = vc / groups;
      longint x      = longint'(b) + longint'(offv * 4);
      int     m      = int'(x % longint'(stride));
      int     first  = m - (m % 4);
      int     n      = (nc == 0) ? int'(sf) : (nc == 1) ? int'(sf & 5'd15) * 2
                                            : int'(sf & 5'd7) * 4;
      for (int r = 0; r < groups; r++)
         for (int i = 0; i < 4; i++)
            q.push_back('{vld: 1, done: 0, row: first + r * stride + i,
                          src: n + r, sub: i});
      q.push_back('{vld: 0, done: 1, row: 0, src: 0, sub: 0});
   endtask

   // one cycle: compare what is shown now, then drive the next inputs
   task automatic step(bit st, logic [31:0] b, logic [1:0] of, logic [1:0] nc,
                       logic [4:0] sf, int vc);
      ent_t e;
      @(negedge clk);
      if (q.size() > 0) e = q.pop_front();
      else e = '{vld: 0, done: 0, row: 0, src: 0, sub: 0};
      chk(vld == e.vld, "R6 vld", int'(vld), int'(e.vld));
      chk(done == e.done, "R6 done", int'(done), int'(e.done));
      if (e.vld && vld) begin
         chk(int'(row) == e.row, (e.sub == 0) ? "R2 R3 row" : "R4 row", int'(row), e.row);
         chk(int'(sub) == e.sub, "R4 sub", int'(sub), e.sub);
         chk(int'(src) == e.src, "R5 src", int'(src), e.src);
      end
      if (st && q.size() == 0 && nc != 2'd3) push_launch(b, of, nc, sf, vc);
      start = st; base = b; off = of; nreg = nc; srcf = sf; vecs = 9'(vc);
   endtask

   task automatic idle(int n);
      for (int k = 0; k < n; k++) step(0, base, off, nreg, srcf, int'(vecs));
   endtask

   task automatic drain();
      while (q.size() > 0) idle(1);
      idle(1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(vld == 1'b0 && done == 1'b0, "R1 reset", int'({vld, done}), 0);
      rst_n = 1'b1;
      idle(2);

      scn = "R2";   // one group, two offset bits, small array
      step(1, 32'd5, 2'd2, 2'd0, 5'd19, 16); drain();
      scn = "R3";   // base wraps past 2^32
      step(1, 32'hFFFF_FFFF, 2'd3, 2'd0, 5'd31, 256); drain();
      scn = "R2";   // two groups: offset bit 1 ignored
      step(1, 32'd30, 2'd3, 2'd1, 5'd31, 64); drain();
      scn = "R5";   // four groups, scaled source field
      step(1, 32'h1234_5679, 2'd1, 2'd2, 5'd21, 256); drain();
      scn = "R3";   // four groups on the smallest array: stride 4
      step(1, 32'd77, 2'd1, 2'd2, 5'd3, 16); drain();

      scn = "R7";   // start while busy
      step(1, 32'd9, 2'd0, 2'd1, 5'd4, 32);
      idle(3);
      step(1, 32'd200, 2'd1, 2'd2, 5'd1, 128);
      idle(3);
      step(1, 32'd1, 2'd1, 2'd0, 5'd2, 128);   // last step shown: still busy
      drain();

      scn = "R9";   // back-to-back in the done cycle
      step(1, 32'd44, 2'd1, 2'd0, 5'd6, 64);
      idle(4);
      step(1, 32'd100, 2'd0, 2'd1, 5'd8, 128);
      drain();

      scn = "R8";   // reserved count code
      step(1, 32'd12, 2'd1, 2'd3, 5'd5, 64);
      idle(8);

      scn = "R4";   // sweep of array sizes and counts
      for (int vs = 0; vs < 5; vs++)
         for (int nc = 0; nc < 3; nc++) begin
            step(1, 32'(vs * 97 + nc * 1013 + 3), 2'(vs + nc), 2'(nc),
                 5'(vs * 7 + nc), 16 << vs);
            drain();
         end

      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog [%s] act=%0d exp=%0d", scn, WATCHDOG, 0);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule